// File: doc/BRIEF.md
# JTAG Vector Shift Engine

This block moves up to 32 bits through a JTAG scan path in one transaction. Software sets it up through a small register bus. It writes a bit count, a word of TMS bits and a word of TDI bits, and optionally a TCK half-period measured in system clocks. It then writes a start command. The engine drives the first TMS/TDI bit straight away, before any TCK edge. It generates exactly as many TCK pulses as the count asks for, and moves TMS and TDI on each falling TCK edge. On each rising edge it samples TDO into a readback word. When the transfer ends, a sticky done flag is raised.

The register bus has no back-pressure. A selected write takes effect on the next clock edge. A selected read returns its data on `bus_rdata` one clock after the request. Register offsets: 0x00 count, 0x04 TMS word, 0x08 TDI word, 0x0C captured TDO word (read only), 0x10 control/status, 0x14 TCK half-period (16 bits).

Top module: `jtag_vec_shifter`

## Requirements
- R1: After reset TCK, TMS and TDI are low, status reads 0, the TDO word reads 0 and the half-period register reads HALF_RESET.
- R2: Writes to offsets 0x00, 0x04, 0x08 and 0x14 read back unchanged; the half-period register keeps bits 15:0.
- R3: A count N in 1..32 produces exactly N rising TCK edges, and TCK is low whenever the engine is not busy.
- R4: TMS and TDI bit i (bit 0 first) are valid at the i-th rising TCK edge; bit 0 is on the pins in the cycle after the start write, before TCK rises.
- R5: TMS and TDI change only while TCK is low, at the edge where TCK falls or at the start.
- R6: TDO sampled at rising edge i lands in bit i of the word at 0x0C; bits at N and above read as 0.
- R7: Writing 1 to bit 0 of 0x10 starts a transfer. The status at 0x10 has bit 0 = busy and bit 1 = done. Done clears on start and stays set until the next start.
- R8: A start write while busy is ignored, and so are config writes during the transfer: the edge count and shifted bits of the running transfer are unchanged.
- R9: A count of 0 or above 32 sets done at once, produces no TCK edge and leaves the TDO word 0.
- R10: Each TCK high phase and each low phase lasts H system clocks, with H the half-period register latched at start; a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| jtag_tck | output | 1 | Test clock, idles low |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to the target |
| jtag_tdo | input | 1 | Test data from the target |

## Verification
The in-line assertions check on every cycle that TCK stays low when the engine is idle and rises only while busy. They also check that TMS and TDI never move while TCK is high, that busy and done are never set together, that the bit index stays within the count, and that the phase counter never passes the latched half-period. Only the bench's scenarios can show the end-to-end behaviour. A target model counts TCK edges, captures TMS and TDI, feeds TDO from a pattern and times the high phases. This covers the exact edge count, the LSB-first order, the TDO packing with zeroed upper bits, the sticky done flag, starts ignored while busy, and invalid counts.

// File: rtl/jvs_pkg.sv
package jvs_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TMS   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TDI   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TDO   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_HALF  = 5'h14;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_HIGH = 2'd2
  } shift_state_t;
endpackage

// File: rtl/jvs_regs.sv
module jvs_regs
  import jvs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HALF_W     = 16,
  parameter int HALF_RESET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] tdo_word,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] tms_q,
  output logic [DATA_W-1:0] tdi_q,
  output logic [HALF_W-1:0] half_q,
  output logic              start,
  output logic [DATA_W-1:0] rdata
);
  logic wr_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en = sel && wr;
  assign start = wr_en && (addr == OFS_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      tms_q   <= '0;
      tdi_q   <= '0;
      half_q  <= HALF_W'(HALF_RESET);
    end else if (wr_en) begin
      case (addr)
        OFS_COUNT: count_q <= wdata;
        OFS_TMS:   tms_q   <= wdata;
        OFS_TDI:   tdi_q   <= wdata;
        OFS_HALF:  half_q  <= wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_COUNT: rd_mux = count_q;
      OFS_TMS:   rd_mux = tms_q;
      OFS_TDI:   rd_mux = tdi_q;
      OFS_TDO:   rd_mux = tdo_word;
      OFS_CTRL:  rd_mux = {{(DATA_W-2){1'b0}}, done, busy};
      OFS_HALF:  rd_mux = {{(DATA_W-HALF_W){1'b0}}, half_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (sel && !wr) rdata <= rd_mux;
  end

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7
endmodule

// File: rtl/jvs_tick.sv
module jvs_tick #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] half_in,
  input  logic              run,
  output logic              tick
);
  logic [HALF_W-1:0] half_lat;
  logic [HALF_W-1:0] ph_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) half_lat <= HALF_W'(1);
    else if (load) half_lat <= (half_in == '0) ? HALF_W'(1) : half_in;
  end

  assign tick = run && (ph_cnt == half_lat - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ph_cnt <= '0;
    else if (tick) ph_cnt <= '0;
    else ph_cnt <= ph_cnt + HALF_W'(1);
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_cnt < half_lat)); // R10
  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    half_lat != '0); // R10
endmodule

// File: rtl/jvs_seq.sv
module jvs_seq
  import jvs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_BITS = 32,
  localparam int IDX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] tms_word,
  input  logic [DATA_W-1:0] tdi_word,
  input  logic              tick,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] tdo_word
);
  shift_state_t      state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last;
  logic [IDX_W-1:0]  nxt;
  logic [DATA_W-1:0] tms_lat;
  logic [DATA_W-1:0] tdi_lat;
  logic              cnt_ok;

  assign busy   = (state != SH_IDLE);
  assign cnt_ok = (count != '0) && (count <= DATA_W'(MAX_BITS));
  assign nxt    = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      idx      <= '0;
      last     <= '0;
      tms_lat  <= '0;
      tdi_lat  <= '0;
      tck_o    <= 1'b0;
      tms_o    <= 1'b0;
      tdi_o    <= 1'b0;
      done     <= 1'b0;
      tdo_word <= '0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start) begin
            tdo_word <= '0;
            if (cnt_ok) begin
              done    <= 1'b0;
              state   <= SH_LOW;
              idx     <= '0;
              last    <= IDX_W'(count - DATA_W'(1));
              tms_lat <= tms_word;
              tdi_lat <= tdi_word;
              tms_o   <= tms_word[0];
              tdi_o   <= tdi_word[0];
            end else begin
              done <= 1'b1;
            end
          end
        end
        SH_LOW: begin
          if (tick) begin
            tck_o         <= 1'b1;
            tdo_word[idx] <= tdo_i;
            state         <= SH_HIGH;
          end
        end
        SH_HIGH: begin
          if (tick) begin
            tck_o <= 1'b0;
            if (idx == last) begin
              state <= SH_IDLE;
              done  <= 1'b1;
            end else begin
              idx   <= nxt;
              tms_o <= tms_lat[nxt];
              tdi_o <= tdi_lat[nxt];
              state <= SH_LOW;
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck_o); // R3
  AST_IDX_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= last)); // R3
  AST_TMS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tms_o != $past(tms_o)) |-> !tck_o); // R5
  AST_TDI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tdi_o != $past(tdi_o)) |-> !tck_o); // R5
  AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy); // R7
endmodule

// File: rtl/jtag_vec_shifter.sv
module jtag_vec_shifter
  import jvs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAX_BITS   = 32,
  parameter int HALF_W     = 16,
  parameter int HALF_RESET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  input  logic              jtag_tdo
);
  logic [DATA_W-1:0] count_q, tms_q, tdi_q, tdo_word;
  logic [HALF_W-1:0] half_q;
  logic start, busy, done, tick;

  jvs_regs #(.DATA_W(DATA_W), .HALF_W(HALF_W), .HALF_RESET(HALF_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .done(done), .tdo_word(tdo_word),
    .count_q(count_q), .tms_q(tms_q), .tdi_q(tdi_q), .half_q(half_q),
    .start(start), .rdata(bus_rdata)
  );

  jvs_tick #(.HALF_W(HALF_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(start && !busy), .half_in(half_q),
    .run(busy), .tick(tick)
  );

  jvs_seq #(.DATA_W(DATA_W), .MAX_BITS(MAX_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count_q),
    .tms_word(tms_q), .tdi_word(tdi_q), .tick(tick), .tdo_i(jtag_tdo),
    .tck_o(jtag_tck), .tms_o(jtag_tms), .tdi_o(jtag_tdi),
    .busy(busy), .done(done), .tdo_word(tdo_word)
  );

  AST_TCK_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jtag_tck) |-> busy); // R3
endmodule

// File: tb/sim_jtag_vec_shifter.sv
module sim_jtag_vec_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 150000;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tck, tms, tdi, tdo = 0;

  int n_run = 0, n_fail = 0;
  int rise_cnt = 0, base = 0;
  int hi_run = 0, last_hi = 0;
  logic [31:0] cap_tms = '0, cap_tdi = '0, tdo_pat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_vec_shifter u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi), .jtag_tdo(tdo)
  );

  // target model
  always @(posedge tck) begin
    rise_cnt = rise_cnt + 1;
    cap_tms = {tms, cap_tms[31:1]};
    cap_tdi = {tdi, cap_tdi[31:1]};
  end
  always @(negedge tck) begin
    if (rise_cnt - base < 32) tdo = tdo_pat[rise_cnt - base];
  end
  always @(negedge clk) begin
    if (tck) hi_run = hi_run + 1;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 2000; k++) begin
      rd(5'h10, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] mask_of(input int n);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic arm(input logic [31:0] pat);
    base = rise_cnt; tdo_pat = pat; tdo = pat[0];
  endtask

  // {count, half, tms, tdi, tdo pattern}
  localparam logic [111:0] VEC [6] = '{
    {8'd32, 8'd1, 32'hAAAA_AAAA, 32'h5555_5555, 32'hC3A5_F00F},
    {8'd32, 8'd2, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678},
    {8'd3,  8'd3, 32'h0000_3344, 32'h0000_1122, 32'h0000_0007},
    {8'd1,  8'd1, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
    {8'd13, 8'd4, 32'h0000_1ABC, 32'h0000_0F0F, 32'hFFFF_FFFF},
    {8'd31, 8'd2, 32'h1122_3344, 32'h55AA_55AA, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", LIMIT);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 tck", {31'd0, tck}, 0);
    check("R1 tms", {31'd0, tms}, 0);
    check("R1 tdi", {31'd0, tdi}, 0);
    rd(5'h10, r); check("R1 status", r, 0);
    rd(5'h0C, r); check("R1 tdo", r, 0);
    rd(5'h14, r); check("R1 half", r, 2);
    // R2 register readback
    wr(5'h00, 32'hA5A5_0003); rd(5'h00, r); check("R2 count", r, 32'hA5A5_0003);
    wr(5'h04, 32'h1357_9BDF); rd(5'h04, r); check("R2 tms", r, 32'h1357_9BDF);
    wr(5'h08, 32'h2468_ACE0); rd(5'h08, r); check("R2 tdi", r, 32'h2468_ACE0);
    wr(5'h14, 32'hFFFF_0007); rd(5'h14, r); check("R2 half", r, 32'h0000_0007);

    // table walk: R3 R4 R6 R7 R10
    foreach (VEC[i]) begin
      int n = int'(VEC[i][111:104]);
      logic [31:0] m = mask_of(n);
      wr(5'h14, {24'd0, VEC[i][103:96]});
      wr(5'h00, n);
      wr(5'h04, VEC[i][95:64]);
      wr(5'h08, VEC[i][63:32]);
      arm(VEC[i][31:0]);
      wr(5'h10, 1);
      wait_idle();
      check("R3 edges", rise_cnt - base, n);
      check("R4 tms bits", (cap_tms >> (32 - n)) & m, VEC[i][95:64] & m);
      check("R4 tdi bits", (cap_tdi >> (32 - n)) & m, VEC[i][63:32] & m);
      rd(5'h0C, r); check("R6 tdo word", r, VEC[i][31:0] & m);
      rd(5'h10, r); check("R7 done", r, 2);
      check("R10 high width", last_hi, int'(VEC[i][103:96]));
      check("R3 tck idle", {31'd0, tck}, 0);
    end

    // R4 R5 first bit before first rise
    wr(5'h14, 8); wr(5'h00, 8); wr(5'h04, 32'h0000_00A1); wr(5'h08, 32'h0000_0001);
    arm(32'h0000_0055);
    wr(5'h10, 1);
    check("R4 first tck low", {31'd0, tck}, 0);
    check("R4 first tms", {31'd0, tms}, 1);
    check("R4 first tdi", {31'd0, tdi}, 1);
    check("R4 no early edge", rise_cnt - base, 0);
    rd(5'h10, r); check("R7 busy", r, 1);
    // R8 start and config writes while busy ignored
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h00, 32); wr(5'h10, 1);
    wait_idle();
    check("R8 edges", rise_cnt - base, 8);
    check("R8 tms bits", cap_tms >> 24, 32'h0000_00A1);
    rd(5'h10, r); check("R7 sticky 1", r, 2);
    repeat (20) @(negedge clk);
    rd(5'h10, r); check("R7 sticky 2", r, 2);
    check("R8 no extra edge", rise_cnt - base, 8);

    // R9 invalid counts
    wr(5'h00, 0); arm(32'hFFFF_FFFF); wr(5'h10, 1);
    repeat (10) @(negedge clk);
    rd(5'h10, r); check("R9 zero done", r, 2);
    check("R9 zero edges", rise_cnt - base, 0);
    rd(5'h0C, r); check("R9 zero tdo", r, 0);
    wr(5'h00, 40); wr(5'h10, 1);
    repeat (10) @(negedge clk);
    rd(5'h10, r); check("R9 big done", r, 2);
    check("R9 big edges", rise_cnt - base, 0);

    // R10 half 0 acts as 1
    wr(5'h14, 0); wr(5'h00, 4); arm(32'h0000_0009); wr(5'h10, 1);
    wait_idle();
    check("R10 half zero", last_hi, 1);
    check("R3 four edges", rise_cnt - base, 4);
    rd(5'h0C, r); check("R6 short word", r, 32'h0000_0009);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule